// File: doc/BRIEF.md
# I2C Controller Interrupt and Enable Unit

This unit collects the event sources of an I2C controller into a single interrupt line, and it holds the controller's enable. Ten of the twelve sources are sticky events. The bit engine raises each of them with a one-cycle pulse. Software clears them by reading a clear register, either one register per source or one register for all sources at once. The other two sources are level conditions. They come from comparing the TX and RX FIFO fill levels against thresholds that software programs. A mask selects which status bits drive the interrupt output.

Software requests enable or disable through one register and observes the real state through a second register. A disable request is honoured only after the master has gone idle. Until then the bit engine stays enabled and the status register keeps reading 1.

Register access is a simple single-cycle port. A read returns data combinationally in the same cycle as `reg_rd`. Any clear-on-read side effect takes place at the clock edge that ends that cycle.

Top module: `irq_unit`

## Requirements
- R1: After reset the following all read 0: the mask, every sticky event, both thresholds, the enable request, the enable status, the abort-cause register and `irq`.
- R2: The status bit positions, from 11 down to 0, are: general call, start seen, stop seen, activity, receive done, transmit abort, read request, TX low, TX overflow, RX threshold, RX overflow and RX underflow. A one-cycle pulse on `evt_pulse[k]` for a sticky bit k sets status bit k at the next clock edge. The bit then stays set. Raw status reads at address 0x01.
- R3: `irq` is high exactly when some bit of (status AND mask) is set. The mask is at address 0x00, using the same bit positions, and the masked status reads at 0x02. A zero mask keeps `irq` low.
- R4: Reading address 0x10+k returns sticky bit k in `reg_rdata[0]` and clears only that bit. If an event pulse for bit k arrives in the same cycle, the bit stays set.
- R5: Reading address 0x08 returns the pending sticky bits in `reg_rdata[11:0]` and clears all of them, unless a pulse for a bit arrives in the same cycle.
- R6: The abort-cause register at 0x07 ORs in `abort_cause` on each `evt_pulse[6]`. A read of 0x16 or of 0x08 clears it; a pulse arriving in the same cycle as that read wins.
- R7: Status bit 2 equals (`rx_level` > RX threshold). The RX threshold is at 0x03.
- R8: Status bit 4 equals (`tx_level` <= TX threshold). The TX threshold is at 0x04.
- R9: Bits 2 and 4 ignore `evt_pulse[2]` and `evt_pulse[4]`, and no clear read changes them.
- R10: Writing 1 to bit 0 of 0x05 sets the enable request, which reads back at 0x05. `en_active` and bit 0 of 0x06 become 1 one clock after the write edge.
- R11: After bit 0 of 0x05 is written 0, `en_active` and the status at 0x06 stay 1 while `master_busy` is high. They fall at the first clock edge at which `master_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clear-on-read side effects) |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid in the cycle of reg_rd |
| evt_pulse | input | 12 | One-cycle event pulses from the bit engine |
| abort_cause | input | ABRT_W | Abort reason bits, sampled with evt_pulse[6] |
| tx_level | input | LVL_W | TX FIFO fill level |
| rx_level | input | LVL_W | RX FIFO fill level |
| master_busy | input | 1 | Master state machine not idle |
| irq | output | 1 | Interrupt request |
| en_active | output | 1 | Effective controller enable |

## Verification
The bench sends a pulse to each of the twelve sources in turn. This separates the sticky bits from the two level bits and catches any swapped positions. Single-bit and all-but-one masks are applied to every source. Clearing works one source at a time, and a selective clear is tried on a full set of events, which shows whether a clear reaches neighbouring bits. Both thresholds are swept over every FIFO level from empty to full, which locates the off-by-one boundaries of the two compares. Collisions between a pulse and a clear, and a disable held off by a busy master, test the ordering corners.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int NUM_SRC = 12;

  localparam int B_RXUNDER = 0;
  localparam int B_RXOVER  = 1;
  localparam int B_RXTHR   = 2;
  localparam int B_TXOVER  = 3;
  localparam int B_TXLOW   = 4;
  localparam int B_RDREQ   = 5;
  localparam int B_ABORT   = 6;
  localparam int B_RXDONE  = 7;
  localparam int B_ACT     = 8;
  localparam int B_STOP    = 9;
  localparam int B_START   = 10;
  localparam int B_GCALL   = 11;

  localparam logic [NUM_SRC-1:0] STICKY_MASK =
    ~((NUM_SRC'(1) << B_RXTHR) | (NUM_SRC'(1) << B_TXLOW));

  localparam int A_MASK   = 'h00;
  localparam int A_RAW    = 'h01;
  localparam int A_PEND   = 'h02;
  localparam int A_RXTHR  = 'h03;
  localparam int A_TXTHR  = 'h04;
  localparam int A_ENREQ  = 'h05;
  localparam int A_ENSTAT = 'h06;
  localparam int A_ABSRC  = 'h07;
  localparam int A_CLRALL = 'h08;
  localparam int A_CLRBASE = 'h10;

  function automatic logic rx_above(input int unsigned lvl, input int unsigned thr);
    return lvl > thr;
  endfunction

  function automatic logic tx_at_or_below(input int unsigned lvl, input int unsigned thr);
    return lvl <= thr;
  endfunction
endpackage

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
  parameter int N = 12,
  parameter logic [N-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_pulse,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (KEEP[i]) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags[i] <= 1'b0;
        else        flags[i] <= set_pulse[i] | (flags[i] & ~clr_vec[i]);
      end
    end else begin : g_none
      assign flags[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_lvl_cmp.sv
module irq_lvl_cmp
  import irq_unit_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_thr,
  input  logic [LVL_W-1:0] rx_thr,
  output logic             tx_low,
  output logic             rx_hit
);
  assign tx_low = tx_at_or_below(int'(tx_level), int'(tx_thr));
  assign rx_hit = rx_above(int'(rx_level), int'(rx_thr));
endmodule

// File: rtl/irq_en_ctl.sv
module irq_en_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic busy,
  output logic en_state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_state <= 1'b0;
    else if (en_req)  en_state <= 1'b1;
    else if (!busy)   en_state <= 1'b0;
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_unit_pkg::*;
#(
  parameter int AW     = 5,
  parameter int DW     = 16,
  parameter int LVL_W  = 5,
  parameter int ABRT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [11:0]       evt_pulse,
  input  logic [ABRT_W-1:0] abort_cause,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              master_busy,
  output logic              irq,
  output logic              en_active
);
  logic [NUM_SRC-1:0] mask_q, sticky, status_vec, pend_vec, clr_vec, sel_one;
  logic [LVL_W-1:0]   tx_thr_q, rx_thr_q;
  logic [ABRT_W-1:0]  abort_src;
  logic               en_req_q, en_state, tx_low, rx_hit;
  logic               rd_clr_all, rd_clr_one;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata;

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      tx_thr_q <= '0;
      rx_thr_q <= '0;
      en_req_q <= 1'b0;
    end else if (reg_wr) begin
      case (int'(reg_addr))
        A_MASK:  mask_q   <= reg_wdata[NUM_SRC-1:0];
        A_RXTHR: rx_thr_q <= reg_wdata[LVL_W-1:0];
        A_TXTHR: tx_thr_q <= reg_wdata[LVL_W-1:0];
        A_ENREQ: en_req_q <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  // clear-on-read decode
  assign rd_clr_all = reg_rd && (int'(reg_addr) == A_CLRALL);
  assign rd_clr_one = reg_rd && ((int'(reg_addr) & A_CLRBASE) != 0);
  assign sel_one    = NUM_SRC'(1) << reg_addr[3:0];
  assign clr_vec    = STICKY_MASK & ({NUM_SRC{rd_clr_all}} | (rd_clr_one ? sel_one : '0));

  irq_evt_bank #(.N(NUM_SRC), .KEEP(STICKY_MASK)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse (evt_pulse),
    .clr_vec   (clr_vec),
    .flags     (sticky)
  );

  irq_lvl_cmp #(.LVL_W(LVL_W)) u_cmp (
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_thr   (tx_thr_q),
    .rx_thr   (rx_thr_q),
    .tx_low   (tx_low),
    .rx_hit   (rx_hit)
  );

  irq_en_ctl u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_req   (en_req_q),
    .busy     (master_busy),
    .en_state (en_state)
  );

  // abort cause accumulates; a new abort wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_src <= '0;
    else if (evt_pulse[B_ABORT])
      abort_src <= (clr_vec[B_ABORT] ? '0 : abort_src) | abort_cause;
    else if (clr_vec[B_ABORT])
      abort_src <= '0;
  end

  always_comb begin
    status_vec = sticky;
    status_vec[B_TXLOW] = tx_low;
    status_vec[B_RXTHR] = rx_hit;
  end

  assign pend_vec  = status_vec & mask_q;
  assign irq       = |pend_vec;
  assign en_active = en_state;

  always_comb begin
    reg_rdata = '0;
    if (rd_clr_one) reg_rdata = DW'(|(sticky & sel_one));
    else begin
      case (int'(reg_addr))
        A_MASK:   reg_rdata = DW'(mask_q);
        A_RAW:    reg_rdata = DW'(status_vec);
        A_PEND:   reg_rdata = DW'(pend_vec);
        A_RXTHR:  reg_rdata = DW'(rx_thr_q);
        A_TXTHR:  reg_rdata = DW'(tx_thr_q);
        A_ENREQ:  reg_rdata = DW'(en_req_q);
        A_ENSTAT: reg_rdata = DW'(en_state);
        A_ABSRC:  reg_rdata = DW'(abort_src);
        A_CLRALL: reg_rdata = DW'(sticky);
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk
  import irq_unit_pkg::*;
#(
  parameter int AW     = 5,
  parameter int ABRT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic [AW-1:0]     reg_addr,
  input logic [11:0]       evt_pulse,
  input logic [11:0]       status,
  input logic [11:0]       mask,
  input logic              irq,
  input logic              en_req,
  input logic              en_state,
  input logic              master_busy,
  input logic [ABRT_W-1:0] abort_src
);
  logic [11:0] k_sel;
  assign k_sel = 12'(1) << reg_addr[3:0];

  // R2: a sticky pulse is visible the next cycle
  p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_pulse & STICKY_MASK)) |=> (($past(evt_pulse) & STICKY_MASK & ~status) == 12'd0));

  // R3: a zero mask silences the line
  p_mask_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 12'd0) |-> !irq);

  // R4: a single clear with no colliding pulse drops the bit
  p_clear_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr[4] && ((k_sel & STICKY_MASK & ~evt_pulse) != 12'd0))
      |=> ((status & $past(k_sel)) == 12'd0));

  // R5: clear-all with no pulse empties the sticky set
  p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (int'(reg_addr) == A_CLRALL) && (evt_pulse == 12'd0))
      |=> ((status & STICKY_MASK) == 12'd0));

  // R6: a recorded abort cause implies the abort event is pending
  p_abort_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_src != '0) |-> status[B_ABORT]);

  // R10: a pending enable request takes effect next cycle
  p_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req && !en_state) |=> en_state);

  // R11: a busy master holds the enable
  p_disable_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_state && master_busy) |=> en_state);
endmodule

bind irq_unit irq_unit_chk #(.AW(AW), .ABRT_W(ABRT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .evt_pulse   (evt_pulse),
  .status      (status_vec),
  .mask        (mask_q),
  .irq         (irq),
  .en_req      (en_req_q),
  .en_state    (en_state),
  .master_busy (master_busy),
  .abort_src   (abort_src)
);

// File: tb/irq_unit_tb_top.sv
module irq_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5, DW = 16, LVL_W = 5, ABRT_W = 8;
  localparam logic [11:0] STICKY = 12'hFEB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic [11:0] evt_pulse = '0;
  logic [ABRT_W-1:0] abort_cause = '0;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
  logic master_busy = 0, irq, en_active;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_unit #(.AW(AW), .DW(DW), .LVL_W(LVL_W), .ABRT_W(ABRT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .abort_cause(abort_cause), .tx_level(tx_level), .rx_level(rx_level),
    .master_busy(master_busy), .irq(irq), .en_active(en_active));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_wr = 1; reg_addr = AW'(a); reg_wdata = DW'(d);
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = AW'(a); #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic pulse(input logic [11:0] v, input logic [ABRT_W-1:0] c);
    @(negedge clk); evt_pulse = v; abort_cause = c;
    @(negedge clk); evt_pulse = '0; abort_cause = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state (tx_level 0 <= thr 0 keeps bit 4 high)
    rd('h00, d); chk("R1 mask", d, 0);
    rd('h01, d); chk("R1 raw", d, 16'h010);
    rd('h07, d); chk("R1 abort src", d, 0);
    rd('h06, d); chk("R1 en stat", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 en_active", en_active, 0);
    tx_level = 16;
    rd('h01, d); chk("R8 tx full not low", d, 0);

    // R2 R3 R4 R9: per-source sweep
    for (int k = 0; k < 12; k++) begin
      logic [11:0] bitk, expv;
      bitk = 12'(1) << k;
      expv = STICKY[k] ? bitk : 12'h0;
      pulse(bitk, 8'h0);
      rd('h01, d); chk(STICKY[k] ? "R2 set" : "R9 pulse ignored", d, 16'(expv));
      wr('h00, 16'(bitk));
      #1 chk("R3 irq one", irq, STICKY[k]);
      rd('h02, d); chk("R3 pend", d, 16'(expv));
      wr('h00, 16'(~bitk & 12'hFFF));
      #1 chk("R3 irq others", irq, 0);
      rd('h10 + k, d); chk("R4 clr return", d, 16'(STICKY[k]));
      rd('h01, d); chk("R4 cleared", d, 0);
    end

    // R5 clear-all, R9 level bits not touched by pulses
    pulse(12'hFFF, 8'h0);
    rd('h01, d); chk("R5 all set", d, 16'hFEB);
    wr('h00, 0);
    #1 chk("R3 zero mask", irq, 0);
    wr('h00, 16'hFFF);
    #1 chk("R3 full mask", irq, 1);
    rd('h09 - 1, d); chk("R5 clr-all return", d, 16'hFEB);
    rd('h01, d); chk("R5 all cleared", d, 0);
    #1 chk("R3 irq dropped", irq, 0);

    // R4 selective clear
    pulse(12'hFEB, 8'h0);
    rd('h19, d); chk("R4 clr bit9", d, 1);
    rd('h01, d); chk("R4 only bit9", d, 16'hDEB);
    rd('h08, d);

    // R4 pulse collides with its clear: set wins
    @(negedge clk); evt_pulse = 12'h008; reg_rd = 1; reg_addr = 5'h13;
    @(negedge clk); evt_pulse = '0; reg_rd = 0;
    rd('h01, d); chk("R4 set wins", d, 16'h008);
    rd('h08, d);

    // R6 abort cause
    pulse(12'h040, 8'h05);
    pulse(12'h040, 8'h30);
    rd('h07, d); chk("R6 accumulate", d, 16'h35);
    rd('h16, d); chk("R6 clr return", d, 1);
    rd('h07, d); chk("R6 cleared", d, 0);
    rd('h01, d); chk("R6 event cleared", d, 0);
    pulse(12'h040, 8'h81);
    rd('h08, d); chk("R6 clr-all return", d, 16'h040);
    rd('h07, d); chk("R6 clr-all src", d, 0);

    // R9 level bits survive clear reads
    wr('h03, 5); wr('h04, 5);
    rx_level = 16; tx_level = 0;
    rd('h12, d); chk("R9 clr lvl rx ret", d, 0);
    rd('h14, d); chk("R9 clr lvl tx ret", d, 0);
    rd('h08, d);
    rd('h01, d); chk("R9 levels stay", d, 16'h014);

    // R7 R8 threshold sweep
    for (int t = 0; t < 16; t++) begin
      wr('h03, t); wr('h04, t);
      for (int l = 0; l <= 16; l++) begin
        rx_level = LVL_W'(l); tx_level = LVL_W'(l);
        rd('h01, d);
        chk("R7 rx thr", d[2], (l > t) ? 1 : 0);
        chk("R8 tx thr", d[4], (l <= t) ? 1 : 0);
      end
    end

    // R10 enable
    wr('h05, 1);
    chk("R10 not yet", en_active, 0);
    @(negedge clk); chk("R10 active", en_active, 1);
    rd('h06, d); chk("R10 en stat", d, 1);
    rd('h05, d); chk("R10 req readback", d, 1);

    // R11 disable waits for idle
    master_busy = 1;
    wr('h05, 0);
    repeat (4) @(negedge clk);
    chk("R11 held", en_active, 1);
    rd('h06, d); chk("R11 stat held", d, 1);
    master_busy = 0;
    #1 chk("R11 still on", en_active, 1);
    @(negedge clk); chk("R11 off", en_active, 0);
    rd('h06, d); chk("R11 stat off", d, 0);
    wr('h05, 1);
    @(negedge clk);
    wr('h05, 0);
    @(negedge clk); chk("R11 idle off", en_active, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule